// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge Handshake

This block gathers up to 32 level-sensitive interrupt lines from peripherals and presents one request line to a host processor's cascade input. Software controls it through four 32-bit registers on a simple write/read port: a configuration word, a per-source enable mask, an in-service set and a vector register. When the request line rises, the host writes an acknowledge bit into the vector register. The controller then freezes the number of the winning source, marks that source as in service, and returns the number on reads in bits [15:11]. The interrupt ends when software writes a one at that source's position in the in-service register.

The winner is chosen by fixed priority, where a smaller index ranks higher. A promotion field in the configuration word can lift one chosen source above all others. A source that is in service blocks every source of equal or lower rank, so only strictly higher-ranked sources can nest on top of it. If software masks a source after it has raised the request but before the acknowledge, no eligible source remains. The acknowledge then returns the reserved error vector 0 and sets no in-service bit. For this reason, input line 0 never acts as a source.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the configuration, mask, in-service and vector registers all read 0, and `irq_req` is low.
- R2: A source requests only while its input is high and its mask bit is 1. The mask is at address 1, with bit i for source i. A masked high source does not raise `irq_req`.
- R3: `irq_req` is high only when the global enable is 1 and some source is eligible. An eligible source is high, unmasked, and outranks every in-service source. The global enable is configuration bit 7 at address 0.
- R4: With promotion at its reset value of 0, a lower source index outranks a higher one.
- R5: Configuration bits [4:0] name a promoted source, which outranks all others. The remaining sources keep index order among themselves.
- R6: Writing address 3 with bit 0 set acknowledges. The winning source number is latched and read back in bits [15:11] of address 3, with the other bits 0. The winner's bit is set in the in-service register at address 2.
- R7: An in-service source blocks sources of equal and lower rank from `irq_req`. A strictly higher-ranked source still raises the request and can be acknowledged on top of it.
- R8: Writing address 2 clears each in-service bit written as 1. Bits written as 0 are left unchanged.
- R9: An acknowledge with no eligible source latches vector 0 and leaves the in-service register unchanged.
- R10: The vector read value stays constant between acknowledges, whatever the inputs do.
- R11: Input line 0 is reserved for the error vector. Mask bit 0 always reads 0, and line 0 never raises `irq_req`.
- R12: `irq_level` follows configuration bits [15:13], which the host uses to route the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_lvl | input | NUM_SRC | Level interrupt inputs, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 config, 1 mask, 2 in-service, 3 vector |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for the selected register (combinational) |
| irq_req | output | 1 | Request to the host cascade input |
| irq_level | output | 3 | Request level field taken from the configuration |

## Verification
The embedded properties assume that the source inputs and register strobes change only away from the active clock edge. They also assume that the in-service register is written only through its own address, never in the same cycle as an acknowledge. The stimulus drives every input on the falling edge and issues one register write per cycle, so both assumptions always hold. The stimulus raises and drops sources while others are in service, and it masks a requesting source before the acknowledge to reach the error vector.

// File: rtl/irqc_pkg.sv
`timescale 1ns/1ps
package irqc_pkg;
   localparam int IDX_W       = 5;
   localparam int CFG_HP_LSB  = 0;
   localparam int CFG_EN_BIT  = 7;
   localparam int CFG_LVL_LSB = 13;
   localparam int LVL_W       = 3;
   localparam int VEC_LSB     = 11;
   localparam int ACK_BIT     = 0;
   localparam logic [IDX_W-1:0] ERR_VEC = '0;

   typedef enum logic [1:0] {
      SEL_CFG    = 2'd0,
      SEL_MASK   = 2'd1,
      SEL_INSVC  = 2'd2,
      SEL_VECTOR = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irqc_arbiter.sv
`timescale 1ns/1ps
module irqc_arbiter #(
   parameter int NUM_SRC    = 32,
   parameter int PROMOTE_EN = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          req,
   input  logic [NUM_SRC-1:0]          insvc,
   input  logic [irqc_pkg::IDX_W-1:0]  hp_sel,
   output logic                        win_valid,
   output logic [irqc_pkg::IDX_W-1:0]  win_idx
);
   localparam int IW = irqc_pkg::IDX_W;

   logic [IW-1:0]      hp_eff;
   logic [NUM_SRC-1:0] req_r, isv_r, elig_r;
   logic [IW-1:0]      win_rank;

   generate
      if (PROMOTE_EN != 0) begin : g_promote
         assign hp_eff = (32'(hp_sel) < NUM_SRC) ? hp_sel : '0;
      end else begin : g_fixed
         assign hp_eff = '0;
      end
   endgenerate

   // source index that occupies a given rank (rank 0 = most urgent)
   function automatic logic [IW-1:0] src_of_rank(input int r, input logic [IW-1:0] h);
      if (r == 0)            return h;
      else if (r <= int'(h)) return IW'(r - 1);
      else                   return IW'(r);
   endfunction

   always_comb begin
      for (int r = 0; r < NUM_SRC; r++) begin
         req_r[r] = req[src_of_rank(r, hp_eff)];
         isv_r[r] = insvc[src_of_rank(r, hp_eff)];
      end
   end

   always_comb begin
      logic seen;
      seen = 1'b0;
      for (int r = 0; r < NUM_SRC; r++) begin
         seen      = seen | isv_r[r];
         elig_r[r] = req_r[r] & ~seen;
      end
   end

   always_comb begin
      win_valid = 1'b0;
      win_rank  = '0;
      for (int r = NUM_SRC - 1; r >= 0; r--) begin
         if (elig_r[r]) begin
            win_valid = 1'b1;
            win_rank  = IW'(r);
         end
      end
   end

   assign win_idx = src_of_rank(int'(win_rank), hp_eff);

   // R4
   win_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> req[win_idx]);
   // R7
   win_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> !insvc[win_idx]);
endmodule

// File: rtl/irqc_regfile.sv
`timescale 1ns/1ps
module irqc_regfile #(
   parameter int NUM_SRC = 32,
   parameter int DATA_W  = 32
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                reg_wr,
   input  logic [1:0]                          reg_addr,
   input  logic [DATA_W-1:0]                   reg_wdata,
   output logic [DATA_W-1:0]                   reg_rdata,
   input  logic                                win_valid,
   input  logic [irqc_pkg::IDX_W-1:0]          win_idx,
   output logic [NUM_SRC-1:0]                  mask_o,
   output logic [NUM_SRC-1:0]                  insvc_o,
   output logic [irqc_pkg::IDX_W-1:0]          hp_o,
   output logic                                en_o,
   output logic [irqc_pkg::LVL_W-1:0]          lvl_o
);
   import irqc_pkg::*;

   logic [IDX_W-1:0]   hp_q;
   logic               en_q;
   logic [LVL_W-1:0]   lvl_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] insvc_q;
   logic [IDX_W-1:0]   vec_q;

   logic wr_cfg, wr_mask, wr_insvc, ack_wr;
   assign wr_cfg   = reg_wr && (reg_sel_e'(reg_addr) == SEL_CFG);
   assign wr_mask  = reg_wr && (reg_sel_e'(reg_addr) == SEL_MASK);
   assign wr_insvc = reg_wr && (reg_sel_e'(reg_addr) == SEL_INSVC);
   assign ack_wr   = reg_wr && (reg_sel_e'(reg_addr) == SEL_VECTOR) && reg_wdata[ACK_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hp_q    <= '0;
         en_q    <= 1'b0;
         lvl_q   <= '0;
         mask_q  <= '0;
         insvc_q <= '0;
         vec_q   <= '0;
      end else begin
         if (wr_cfg) begin
            hp_q  <= reg_wdata[CFG_HP_LSB +: IDX_W];
            en_q  <= reg_wdata[CFG_EN_BIT];
            lvl_q <= reg_wdata[CFG_LVL_LSB +: LVL_W];
         end
         if (wr_mask) begin
            mask_q <= {reg_wdata[NUM_SRC-1:1], 1'b0};
         end
         if (wr_insvc) begin
            insvc_q <= insvc_q & ~reg_wdata[NUM_SRC-1:0];
         end else if (ack_wr && win_valid) begin
            insvc_q[win_idx] <= 1'b1;
         end
         if (ack_wr) begin
            vec_q <= win_valid ? win_idx : ERR_VEC;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_sel_e'(reg_addr))
         SEL_CFG: begin
            reg_rdata[CFG_HP_LSB +: IDX_W]  = hp_q;
            reg_rdata[CFG_EN_BIT]           = en_q;
            reg_rdata[CFG_LVL_LSB +: LVL_W] = lvl_q;
         end
         SEL_MASK:   reg_rdata[NUM_SRC-1:0] = mask_q;
         SEL_INSVC:  reg_rdata[NUM_SRC-1:0] = insvc_q;
         SEL_VECTOR: reg_rdata[VEC_LSB +: IDX_W] = vec_q;
         default:    reg_rdata = '0;
      endcase
   end

   assign mask_o  = mask_q;
   assign insvc_o = insvc_q;
   assign hp_o    = hp_q;
   assign en_o    = en_q;
   assign lvl_o   = lvl_q;

   // R6
   ack_marks_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && win_valid) |=> insvc_q[$past(win_idx)]);
   // R9
   err_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !win_valid) |=> (vec_q == ERR_VEC) && (insvc_q == $past(insvc_q)));
   // R10
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_wr |=> $stable(vec_q));
   // R8
   w1c_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_insvc |=> ((insvc_q & ~$past(insvc_q)) == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl #(
   parameter int NUM_SRC    = 32,
   parameter int DATA_W     = 32,
   parameter int PROMOTE_EN = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SRC-1:0]         src_lvl,
   input  logic                       reg_wr,
   input  logic [1:0]                 reg_addr,
   input  logic [DATA_W-1:0]          reg_wdata,
   output logic [DATA_W-1:0]          reg_rdata,
   output logic                       irq_req,
   output logic [2:0]                 irq_level
);
   import irqc_pkg::*;

   generate
      if (NUM_SRC < 2 || NUM_SRC > (1 << IDX_W)) begin : g_bad_src
         $error("vec_irq_ctrl: NUM_SRC must lie in 2..32");
      end
      if (DATA_W < NUM_SRC || DATA_W < CFG_LVL_LSB + LVL_W) begin : g_bad_data
         $error("vec_irq_ctrl: DATA_W too narrow for mask or vector fields");
      end
   endgenerate

   logic [NUM_SRC-1:0] mask_w, insvc_w;
   logic [IDX_W-1:0]   hp_w, win_idx;
   logic               en_w, win_valid;
   logic [LVL_W-1:0]   lvl_w;

   irqc_regfile #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .mask_o    (mask_w),
      .insvc_o   (insvc_w),
      .hp_o      (hp_w),
      .en_o      (en_w),
      .lvl_o     (lvl_w)
   );

   irqc_arbiter #(.NUM_SRC(NUM_SRC), .PROMOTE_EN(PROMOTE_EN)) arb_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (src_lvl & mask_w),
      .insvc     (insvc_w),
      .hp_sel    (hp_w),
      .win_valid (win_valid),
      .win_idx   (win_idx)
   );

   assign irq_req   = en_w & win_valid;
   assign irq_level = lvl_w;

   // R11
   line0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_lvl == NUM_SRC'(1)) |-> !irq_req);
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_lvl = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_req;
   logic [2:0]  irq_level;

   always #10 clk = ~clk;

   vec_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_req(irq_req), .irq_level(irq_level)
   );

   int n_chk = 0, n_bad = 0;
   bit running = 0, done = 0;

   // behavioural reference state
   logic [31:0] m_mask = '0, m_isv = '0;
   int m_hp = 0, m_lvl = 0, m_vec = 0;
   bit m_en = 0;

   function automatic int m_prio(int i);
      return (i == m_hp) ? -1 : i;
   endfunction

   function automatic int m_winner();
      int ceiling = 100, best = -1, bp = 100;
      for (int i = 0; i < 32; i++)
         if (m_isv[i] && m_prio(i) < ceiling) ceiling = m_prio(i);
      for (int i = 1; i < 32; i++)
         if (src_lvl[i] && m_mask[i] && m_prio(i) < ceiling && m_prio(i) < bp) begin
            bp = m_prio(i); best = i;
         end
      return best;
   endfunction

   task automatic chk(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always begin
      @(negedge clk); #5;
      if (running) begin
         chk("R3 irq_req per-cycle", irq_req, (m_en && m_winner() >= 0));
         chk("R12 irq_level per-cycle", irq_level, m_lvl);
      end
   end

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      int w;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      w = m_winner();
      @(posedge clk);
      case (a)
         2'd0: begin m_hp = int'(d[4:0]); m_en = d[7]; m_lvl = int'(d[15:13]); end
         2'd1: m_mask = d & ~32'h1;
         2'd2: m_isv = m_isv & ~d;
         default: if (d[0]) begin
            if (w >= 0) begin m_vec = w; m_isv[w] = 1'b1; end
            else m_vec = 0;
         end
      endcase
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #5 chk(tag, reg_rdata, exp);
   endtask

   task automatic set_src(input logic [31:0] v);
      @(negedge clk);
      src_lvl = v;
   endtask

   task automatic irq_is(input bit exp, input string tag);
      @(negedge clk);
      #5 chk(tag, irq_req, exp);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      running = 1;
      // R1 reset state
      rd(2'd0, 32'h0, "R1 cfg after reset");
      rd(2'd1, 32'h0, "R1 mask after reset");
      rd(2'd2, 32'h0, "R1 insvc after reset");
      rd(2'd3, 32'h0, "R1 vector after reset");
      irq_is(0, "R1 irq after reset");
      // R12 level field, enable on
      wr(2'd0, 32'h0000_A080);
      rd(2'd0, 32'h0000_A080, "R12 cfg readback");
      @(negedge clk); #5 chk("R12 irq_level", irq_level, 5);
      // R2 masking
      set_src(32'h0000_0020);
      irq_is(0, "R2 masked source silent");
      wr(2'd1, 32'h0000_0020);
      irq_is(1, "R2 unmasked source requests");
      // R3 global enable gates
      wr(2'd0, 32'h0000_A000);
      irq_is(0, "R3 enable clear blocks request");
      wr(2'd0, 32'h0000_A080);
      // R4 fixed priority, R6 acknowledge
      wr(2'd1, 32'hFFFF_FFFF);
      set_src(32'h0000_0228);
      wr(2'd3, 32'h1);
      rd(2'd3, 32'h0000_1800, "R4 R6 vector 3 wins");
      rd(2'd2, 32'h0000_0008, "R6 insvc bit 3 set");
      irq_is(0, "R7 lower ranks blocked");
      // R7 nesting by higher rank
      set_src(32'h0000_022C);
      irq_is(1, "R7 higher rank preempts");
      wr(2'd3, 32'h1);
      rd(2'd3, 32'h0000_1000, "R7 nested vector 2");
      rd(2'd2, 32'h0000_000C, "R7 insvc 2 and 3");
      // R8 write-one-to-clear
      set_src(32'h0000_0228);
      wr(2'd2, 32'h0000_0004);
      rd(2'd2, 32'h0000_0008, "R8 clear bit 2");
      wr(2'd2, 32'h0000_0000);
      rd(2'd2, 32'h0000_0008, "R8 zero write no effect");
      wr(2'd2, 32'h0000_0008);
      rd(2'd2, 32'h0000_0000, "R8 clear bit 3");
      set_src(32'h0000_0220);
      irq_is(1, "R3 pending after end of interrupt");
      // R5 promotion of source 9
      wr(2'd0, 32'h0000_A089);
      wr(2'd3, 32'h1);
      rd(2'd3, 32'h0000_4800, "R5 promoted source 9 wins");
      // R10 vector stable between acknowledges
      set_src(32'h0000_0222);
      repeat (3) @(negedge clk);
      rd(2'd3, 32'h0000_4800, "R10 vector held");
      irq_is(0, "R5 promoted in service blocks all");
      wr(2'd2, 32'h0000_0200);
      wr(2'd0, 32'h0000_A080);
      // R11 line 0 reserved
      set_src(32'h0000_0001);
      rd(2'd1, 32'hFFFF_FFFE, "R11 mask bit 0 reads 0");
      irq_is(0, "R11 line 0 never requests");
      // R9 mask race gives error vector
      set_src(32'h0000_0080);
      irq_is(1, "R9 source 7 requests");
      wr(2'd1, 32'hFFFF_FF7F);
      irq_is(0, "R9 masked before acknowledge");
      wr(2'd3, 32'h1);
      rd(2'd3, 32'h0000_0000, "R9 error vector 0");
      rd(2'd2, 32'h0000_0000, "R9 insvc unchanged");
      repeat (2) @(negedge clk);
      running = 0;
      summary();
   end
endmodule